// File: doc/BRIEF.md
# Quadrature Transmit Level Generator

This block turns a stream of 12-bit unsigned audio samples into a matched pair of in-phase and quadrature drive levels for the two PWM DAC channels of a quadrature sampling exciter. Each accepted sample loses its mid-scale offset of 2048 and is pushed into a 15-entry signed delay line. The in-phase signal is the centre entry of that line. The quadrature signal is a sparse, antisymmetric 15-tap Hilbert sum over the same line. This gives two signals about 90 degrees apart with equal group delay.

Both signals are divided by 8 and offset to 125, which is the middle of a 250-count PWM period. They are then clipped to 0..250 and registered. The two levels change together and come with a one-cycle update strobe. Upstream filtering and decimation, the ADC and the PWM counters are outside this block.

Top module: `qtx_quad_gen`

## Requirements
- R1: Reset clears all delay-line entries to zero, drives `lvl_i` and `lvl_q` to 125 and holds `lvl_strobe` low. A mid-scale sample (2048) accepted right after reset therefore yields 125 on both levels.
- R2: An accepted sample `s` enters the line as the signed value `s - 2048` at the newest position, index 14. Every other entry moves one index down, from k+1 to k, and entry 0 is dropped.
- R3: Cycles with `smp_valid` low neither shift the line nor change `lvl_i`/`lvl_q`, whatever `smp_data` holds.
- R4: `lvl_i` = clip(125 + trunc(A[7] / 8)), where A[7] is the sample accepted seven strobes before the newest one.
- R5: `lvl_q` = clip(125 + trunc(trunc(H / 4096) / 8)), with H = (A[0]-A[14])*315 + (A[2]-A[12])*440 + (A[4]-A[10])*734 + (A[6]-A[8])*2202.
- R6: Every division truncates toward zero, also for negative values. For example, A[7] = -9 gives `lvl_i` = 124, not 123.
- R7: Both levels are clipped to the range 0..250. 250 is the PWM period and 125 is the bias.
- R8: `lvl_strobe` is high for exactly the one cycle after each cycle in which `smp_valid` was high. Both levels take their new values on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Audio sample strobe |
| smp_data | input | 12 | Unsigned audio sample, mid-scale 2048 |
| lvl_strobe | output | 1 | Levels updated on the last edge |
| lvl_i | output | 8 | In-phase PWM level, 0..250 |
| lvl_q | output | 8 | Quadrature PWM level, 0..250 |

## Verification
The shift, the Hilbert sum and both level mappings are combinational ahead of a single output register. So the levels and the strobe for a sample presented with `smp_valid` at an edge are due immediately after that edge. The bench drives inputs on falling edges. It compares the outputs on the next falling edge against a software model of the delay line that uses integer division, which truncates toward zero. During idle stretches, the same falling-edge samples check that the strobe stays low and the levels hold. The first sample after an idle stretch is then compared with the unshifted model.

// File: rtl/qtx_pkg.sv
package qtx_pkg;

    typedef logic signed [31:0] acc_t;

    // Nonzero Hilbert weights, indexed by pair number (tap distance 2*p from the oldest end).
    function automatic int hilbert_weight(input int p);
        case (p)
            0:       return 315;
            1:       return 440;
            2:       return 734;
            3:       return 2202;
            default: return 0;
        endcase
    endfunction

    // Divide by 2**sh, rounding toward zero.
    function automatic acc_t div_pow2_tz(input acc_t x, input int sh);
        acc_t bias;
        if (sh == 0) return x;
        bias = (32'sd1 <<< sh) - 32'sd1;
        if (x < 0) return (x + bias) >>> sh;
        return x >>> sh;
    endfunction

    typedef struct packed {
        logic [7:0] in_phase;
        logic [7:0] quad;
    } level_pair_t;

endpackage

// File: rtl/qtx_delay_line.sv
module qtx_delay_line #(
    parameter int DW   = 13,
    parameter int TAPS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] line_nxt [TAPS]
);
    logic signed [DW-1:0] line_q [TAPS];

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        if (t == TAPS - 1) begin : g_newest
            assign line_nxt[t] = shift_en ? din : line_q[t];
        end else begin : g_older
            assign line_nxt[t] = shift_en ? line_q[t+1] : line_q[t];
        end
    end

    always_ff @(posedge clk) begin
        for (int t = 0; t < TAPS; t++) begin
            if (rst) line_q[t] <= '0;
            else     line_q[t] <= line_nxt[t];
        end
    end
endmodule

// File: rtl/qtx_hilbert.sv
module qtx_hilbert
    import qtx_pkg::*;
#(
    parameter int DW   = 13,
    parameter int TAPS = 15
) (
    input  logic signed [DW-1:0] line [TAPS],
    output acc_t                 acc
);
    localparam int CENTER = (TAPS - 1) / 2;
    localparam int NPAIR  = (CENTER + 1) / 2;

    acc_t prod [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = 2 * p;
        localparam int HI = TAPS - 1 - 2 * p;
        acc_t diff;
        assign diff    = acc_t'(line[LO]) - acc_t'(line[HI]);
        assign prod[p] = diff * acc_t'(hilbert_weight(p));
    end

    always_comb begin
        acc = '0;
        for (int p = 0; p < NPAIR; p++) acc = acc + prod[p];
    end
endmodule

// File: rtl/qtx_level_map.sv
module qtx_level_map
    import qtx_pkg::*;
#(
    parameter int PRE_SHIFT  = 0,
    parameter int OUT_SHIFT  = 3,
    parameter int DAC_PERIOD = 250,
    parameter int LVL_W      = 8
) (
    input  acc_t             val,
    output logic [LVL_W-1:0] level
);
    localparam acc_t BIAS = acc_t'(DAC_PERIOD / 2);
    localparam acc_t TOP  = acc_t'(DAC_PERIOD);

    acc_t scaled;
    acc_t biased;

    always_comb begin
        scaled = div_pow2_tz(div_pow2_tz(val, PRE_SHIFT), OUT_SHIFT);
        biased = scaled + BIAS;
        if (biased < 0)        level = '0;
        else if (biased > TOP) level = LVL_W'(TOP);
        else                   level = LVL_W'(biased);
    end
endmodule

// File: rtl/qtx_quad_gen.sv
module qtx_quad_gen
    import qtx_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int TAPS       = 15,
    parameter int HILB_SHIFT = 12,
    parameter int OUT_SHIFT  = 3,
    parameter int DAC_PERIOD = 250,
    parameter int LVL_W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                lvl_strobe,
    output logic [LVL_W-1:0]    lvl_i,
    output logic [LVL_W-1:0]    lvl_q
);
    localparam int DW     = SAMPLE_W + 1;
    localparam int MID    = 1 << (SAMPLE_W - 1);
    localparam int CENTER = (TAPS - 1) / 2;
    localparam int BIAS   = DAC_PERIOD / 2;

    logic signed [DW-1:0] centred;
    logic signed [DW-1:0] line_nxt [TAPS];
    acc_t                 hilb_acc;
    level_pair_t          nxt;

    assign centred = $signed({1'b0, smp_data}) - $signed(DW'(MID));

    qtx_delay_line #(.DW(DW), .TAPS(TAPS)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (smp_valid),
        .din      (centred),
        .line_nxt (line_nxt)
    );

    qtx_hilbert #(.DW(DW), .TAPS(TAPS)) u_hilb (
        .line (line_nxt),
        .acc  (hilb_acc)
    );

    qtx_level_map #(.PRE_SHIFT(0), .OUT_SHIFT(OUT_SHIFT),
                    .DAC_PERIOD(DAC_PERIOD), .LVL_W(LVL_W)) u_map_i (
        .val   (acc_t'(line_nxt[CENTER])),
        .level (nxt.in_phase)
    );

    qtx_level_map #(.PRE_SHIFT(HILB_SHIFT), .OUT_SHIFT(OUT_SHIFT),
                    .DAC_PERIOD(DAC_PERIOD), .LVL_W(LVL_W)) u_map_q (
        .val   (hilb_acc),
        .level (nxt.quad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_strobe <= 1'b0;
            lvl_i      <= LVL_W'(BIAS);
            lvl_q      <= LVL_W'(BIAS);
        end else begin
            lvl_strobe <= smp_valid;
            if (smp_valid) begin
                lvl_i <= nxt.in_phase;
                lvl_q <= nxt.quad;
            end
        end
    end
endmodule

// File: rtl/qtx_quad_gen_chk.sv
module qtx_quad_gen_chk #(
    parameter int DAC_PERIOD = 250,
    parameter int LVL_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             lvl_strobe,
    input logic [LVL_W-1:0] lvl_i,
    input logic [LVL_W-1:0] lvl_q
);
    localparam logic [LVL_W-1:0] BIAS = LVL_W'(DAC_PERIOD / 2);
    localparam logic [LVL_W-1:0] TOP  = LVL_W'(DAC_PERIOD);

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lvl_i == BIAS && lvl_q == BIAS && !lvl_strobe));

    // R8
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> lvl_strobe);

    // R8
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !lvl_strobe);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(lvl_i) && $stable(lvl_q)));

    // R7
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_i <= TOP && lvl_q <= TOP));
endmodule

bind qtx_quad_gen qtx_quad_gen_chk #(.DAC_PERIOD(DAC_PERIOD), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .lvl_strobe (lvl_strobe),
    .lvl_i      (lvl_i),
    .lvl_q      (lvl_q)
);

// File: tb/qtx_quad_gen_tb.sv
`timescale 1ns/1ps
module qtx_quad_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [11:0] smp_data = 12'd2048;
    logic       lvl_strobe;
    logic [7:0] lvl_i, lvl_q;

    int n_tests = 0;
    int n_fail  = 0;
    int model [15];

    always #2 clk = ~clk;

    qtx_quad_gen u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .lvl_strobe(lvl_strobe), .lvl_i(lvl_i), .lvl_q(lvl_q)
    );

    function automatic int clip(input int v);
        if (v < 0) return 0;
        if (v > 250) return 250;
        return v;
    endfunction

    function automatic int exp_i();
        return clip(125 + model[7] / 8);
    endfunction

    function automatic int exp_q();
        int h;
        h = (model[0] - model[14]) * 315 + (model[2] - model[12]) * 440
          + (model[4] - model[10]) * 734 + (model[6] - model[8]) * 2202;
        return clip(125 + (h / 4096) / 8);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 15; k++) model[k] = 0;
    endtask

    task automatic model_push(input int s);
        for (int k = 0; k < 14; k++) model[k] = model[k+1];
        model[14] = s - 2048;
    endtask

    // Present one sample; check the outputs one edge later.
    task automatic send(input int s, input string req);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 12'(s);
        model_push(s);
        @(negedge clk);
        smp_valid = 1'b0;
        check({req, " strobe (R8)"}, int'(lvl_strobe), 1);
        check({req, " lvl_i (R4)"}, int'(lvl_i), exp_i());
        check({req, " lvl_q (R5)"}, int'(lvl_q), exp_q());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset lvl_i", int'(lvl_i), 125);
        check("R1 reset lvl_q", int'(lvl_q), 125);
        check("R1 reset strobe", int'(lvl_strobe), 0);
        send(2048, "R1 midscale after reset");
        check("R1 midscale i", int'(lvl_i), 125);
        check("R1 midscale q", int'(lvl_q), 125);
    endtask

    task automatic t_impulse();
        send(2048 + 800, "R2 impulse");
        for (int k = 0; k < 15; k++) send(2048, "R2 impulse walk");
    endtask

    task automatic t_back_to_back();
        int s;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k > 0) begin
                check("R8 b2b strobe", int'(lvl_strobe), 1);
                check("R4 b2b lvl_i", int'(lvl_i), exp_i());
                check("R5 b2b lvl_q", int'(lvl_q), exp_q());
            end
            s = 2048 + ((k * 373) % 1400) - 700;
            smp_valid = 1'b1;
            smp_data  = 12'(s);
            model_push(s);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        check("R8 b2b last strobe", int'(lvl_strobe), 1);
        check("R4 b2b last lvl_i", int'(lvl_i), exp_i());
        check("R5 b2b last lvl_q", int'(lvl_q), exp_q());
    endtask

    task automatic t_idle();
        int hi, hq;
        send(2048 + 333, "R3 pre-idle");
        hi = int'(lvl_i);
        hq = int'(lvl_q);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            smp_data = 12'(k * 701);
            check("R3 idle strobe", int'(lvl_strobe), 0);
            check("R3 idle lvl_i", int'(lvl_i), hi);
            check("R3 idle lvl_q", int'(lvl_q), hq);
        end
        send(2048 - 150, "R3 post-idle unshifted");
    endtask

    task automatic t_trunc();
        do_reset();
        send(2048 - 9, "R6 neg sample");
        for (int k = 0; k < 7; k++) send(2048, "R6 walk");
        check("R6 trunc toward zero lvl_i", int'(lvl_i), 124);
        do_reset();
        send(2048 + 9, "R6 pos sample");
        for (int k = 0; k < 7; k++) send(2048, "R6 walk pos");
        check("R6 positive trunc lvl_i", int'(lvl_i), 126);
    endtask

    task automatic t_clip();
        do_reset();
        send(4095, "R7 full high");
        for (int k = 0; k < 7; k++) send(2048, "R7 walk");
        check("R7 clip high lvl_i", int'(lvl_i), 250);
        do_reset();
        send(0, "R7 full low");
        for (int k = 0; k < 7; k++) send(2048, "R7 walk low");
        check("R7 clip low lvl_i", int'(lvl_i), 0);
        do_reset();
        for (int k = 0; k < 15; k++) send(((k % 2) == 0) ? 4095 : 0, "R7 alternating");
        for (int k = 0; k < 15; k++) send((k < 7) ? 4095 : 0, "R7 step");
    endtask

    task automatic t_sine();
        do_reset();
        for (int k = 0; k < 40; k++) begin
            real ph;
            ph = 6.2831853 * real'(k) / 13.0;
            send(2048 + int'($rtoi(1500.0 * $sin(ph))), "R5 tone");
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        t_reset();
        t_impulse();
        t_back_to_back();
        t_idle();
        t_trunc();
        t_clip();
        t_sine();
        finish_run();
    end
endmodule